// File: doc/BRIEF.md
# Event Interrupt Status Registers

This block gathers single-cycle event pulses from a serial transfer controller, with the word-complete event as the main one. It keeps them as sticky status bits and combines them with a per-event enable mask to drive one level-sensitive interrupt request. Software reaches the block through a simple register port. There is one shared address, a write strobe and write data. Read data follows the address combinationally.

Four word addresses are decoded. Each carries its own semantics, so that no read-modify-write is ever needed:

- 0x20 shows status before masking, and writing ones there sets status bits so software can test the interrupt path.
- 0x24 shows status after masking, and writing ones there clears status bits.
- 0x28 sets enable bits.
- 0x2C clears enable bits.

The word-complete event sits on bit 1 of the event input and of every register.

Top module: `irq_status_unit`

## Requirements
- R1: Reset (synchronous, active high) clears every status and enable bit. Afterwards every register reads zero and `irq` is low.
- R2: A one on bit i of `evt_pulse` sets status bit i at the next clock edge, whatever the enable mask holds. The bit then reads back as one at address 0x20.
- R3: A read of address 0x24 returns the status bits ANDed with the enable bits. Data bits at and above NUM_EVT read as zero at every address.
- R4: Writing at address 0x28 sets every enable bit whose data bit is one. Enable bits whose data bit is zero keep their value. Reads of 0x28 return the enable mask.
- R5: Writing at address 0x2C clears every enable bit whose data bit is one. Other enable bits keep their value. Reads of 0x2C return the enable mask.
- R6: Writing at address 0x24 clears every status bit whose data bit is one, whether or not that bit is enabled. Status bits whose data bit is zero keep their value.
- R7: Writing at address 0x20 sets every status bit whose data bit is one. Status bits whose data bit is zero keep their value.
- R8: `irq` is high exactly when some status bit and its enable bit are both one. Once high, it stays high through cycles without a register write.
- R9: When an event pulse and a clearing write at 0x24 hit the same status bit in one cycle, the bit ends up set.
- R10: Writes to any address other than the four above change no state, and reads of them return zero. Write data bits at and above NUM_EVT are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | NUM_EVT | One-cycle event pulses; bit 1 is word-complete |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for both read and write |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
An event pulse can land in the same cycle as a clearing write to 0x24 that names the same bit. The bench provokes this by driving the word-complete pulse together with an all-ones write at 0x24. It then judges the outcome from the raw status read and from `irq`, and both must show the bit still pending. Other bits named in that same write must come out cleared.

// File: rtl/irq_su_pkg.sv
package irq_su_pkg;

    // Register word offsets (byte addresses)
    localparam logic [31:0] OFS_RAW    = 32'h20;
    localparam logic [31:0] OFS_MASKED = 32'h24;
    localparam logic [31:0] OFS_EN_SET = 32'h28;
    localparam logic [31:0] OFS_EN_CLR = 32'h2C;

    // Event bit carrying the word-complete pulse
    localparam int unsigned WORD_DONE_BIT = 1;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_RAW,
        RGN_MASKED,
        RGN_EN_SET,
        RGN_EN_CLR
    } region_e;

    typedef struct packed {
        logic raw_set;
        logic sts_clr;
        logic en_set;
        logic en_clr;
    } wr_sel_t;

    function automatic region_e addr_region(input logic [31:0] a);
        region_e r;
        case (a)
            OFS_RAW:    r = RGN_RAW;
            OFS_MASKED: r = RGN_MASKED;
            OFS_EN_SET: r = RGN_EN_SET;
            OFS_EN_CLR: r = RGN_EN_CLR;
            default:    r = RGN_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_su_decode.sv
module irq_su_decode
    import irq_su_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output wr_sel_t           sel
);

    always_comb begin
        region = addr_region(32'(addr));
        sel    = '0;
        if (wr) begin
            sel.raw_set = (region == RGN_RAW);
            sel.sts_clr = (region == RGN_MASKED);
            sel.en_set  = (region == RGN_EN_SET);
            sel.en_clr  = (region == RGN_EN_CLR);
        end
    end

endmodule

// File: rtl/irq_su_status.sv
module irq_su_status #(
    parameter int NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt,
    input  logic [NUM_EVT-1:0] set_mask,
    input  logic [NUM_EVT-1:0] clr_mask,
    output logic [NUM_EVT-1:0] status
);

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                status[i] <= 1'b0;
            else
                // a pulse or a software set overrides a clear in the same cycle
                status[i] <= (status[i] & ~clr_mask[i]) | set_mask[i] | evt[i];
        end
    end

    // R2 and R9: every pulsed bit is set one cycle later, clear or not
    a_r2_evt_sets: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((status & $past(evt)) == $past(evt)));

    // R6: bits named by a clear and not pulsed end up zero
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
        ((clr_mask & ~evt & ~set_mask) != '0)
        |=> ((status & $past(clr_mask & ~evt & ~set_mask)) == '0));

    // R7: software set forces the bits high
    a_r7_sw_set: assert property (@(posedge clk) disable iff (rst)
        (set_mask != '0) |=> ((status & $past(set_mask)) == $past(set_mask)));

endmodule

// File: rtl/irq_su_enable.sv
module irq_su_enable #(
    parameter int NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] set_mask,
    input  logic [NUM_EVT-1:0] clr_mask,
    output logic [NUM_EVT-1:0] enable
);

    always_ff @(posedge clk) begin
        if (rst)
            enable <= '0;
        else
            enable <= (enable | set_mask) & ~clr_mask;
    end

    a_r4_en_set: assert property (@(posedge clk) disable iff (rst)
        (set_mask != '0) |=> ((enable & $past(set_mask)) == $past(set_mask)));

    a_r5_en_clr: assert property (@(posedge clk) disable iff (rst)
        (clr_mask != '0) |=> ((enable & $past(clr_mask)) == '0));

    // set and clear come from distinct addresses, never together
    a_r10_one_mask: assert property (@(posedge clk) disable iff (rst)
        !((set_mask != '0) && (clr_mask != '0)));

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_su_pkg::*;
#(
    parameter int NUM_EVT = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq
);

    localparam int EVT_MSB = NUM_EVT - 1;

    region_e            region;
    wr_sel_t            sel;
    logic [EVT_MSB:0]   wbits;
    logic [EVT_MSB:0]   status;
    logic [EVT_MSB:0]   enable;
    logic [EVT_MSB:0]   pending;
    logic               unused_wdata_hi;

    assign wbits           = reg_wdata[EVT_MSB:0];
    assign unused_wdata_hi = ^reg_wdata;

    irq_su_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr     (reg_wr),
        .addr   (reg_addr),
        .region (region),
        .sel    (sel)
    );

    irq_su_status #(.NUM_EVT(NUM_EVT)) u_status (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_pulse),
        .set_mask (wbits & {NUM_EVT{sel.raw_set}}),
        .clr_mask (wbits & {NUM_EVT{sel.sts_clr}}),
        .status   (status)
    );

    irq_su_enable #(.NUM_EVT(NUM_EVT)) u_enable (
        .clk      (clk),
        .rst      (rst),
        .set_mask (wbits & {NUM_EVT{sel.en_set}}),
        .clr_mask (wbits & {NUM_EVT{sel.en_clr}}),
        .enable   (enable)
    );

    assign pending = status & enable;
    assign irq     = |pending;

    always_comb begin
        reg_rdata = '0;
        case (region)
            RGN_RAW:                reg_rdata[EVT_MSB:0] = status;
            RGN_MASKED:             reg_rdata[EVT_MSB:0] = pending;
            RGN_EN_SET, RGN_EN_CLR: reg_rdata[EVT_MSB:0] = enable;
            default:                reg_rdata = '0;
        endcase
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (status == '0 && enable == '0 && !irq));

    a_r8_irq_holds: assert property (@(posedge clk) disable iff (rst)
        (irq && !reg_wr) |=> irq);

    a_r10_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && region == RGN_NONE && evt_pulse == '0)
        |=> ($stable(status) && $stable(enable)));

    a_r3_masked_subset: assert property (@(posedge clk) disable iff (rst)
        (region == RGN_MASKED) |-> ((reg_rdata[EVT_MSB:0] & ~enable) == '0));

endmodule

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;

    localparam int NUM_EVT = 4;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_EVT-1:0] evt_pulse = '0;
    logic               reg_wr = 1'b0;
    logic [ADDR_W-1:0]  reg_addr = '0;
    logic [DATA_W-1:0]  reg_wdata = '0;
    logic [DATA_W-1:0]  reg_rdata;
    logic               irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    irq_status_unit #(.NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_irq_status_unit (
        .clk       (clk),
        .rst       (rst),
        .evt_pulse (evt_pulse),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  waddr;
        logic [31:0] wdata;
        logic [3:0]  evt;
        logic [7:0]  raddr;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [3:0]  req;
    } step_t;

    localparam int NSTEP = 15;
    localparam step_t STEPS [NSTEP] = '{
        '{1'b0, 8'h00, 32'h0,        4'h2, 8'h20, 32'h2, 1'b0, 4'd2 },  // R2 pulse sets raw
        '{1'b0, 8'h00, 32'h0,        4'h0, 8'h24, 32'h0, 1'b0, 4'd3 },  // R3 masked is zero
        '{1'b1, 8'h28, 32'h2,        4'h0, 8'h24, 32'h2, 1'b1, 4'd4 },  // R4 enable bit 1
        '{1'b1, 8'h28, 32'h0,        4'h0, 8'h28, 32'h2, 1'b1, 4'd4 },  // R4 zeros keep
        '{1'b1, 8'h24, 32'h0,        4'h0, 8'h20, 32'h2, 1'b1, 4'd6 },  // R6 zeros keep
        '{1'b1, 8'h24, 32'h2,        4'h0, 8'h20, 32'h0, 1'b0, 4'd6 },  // R6 clear
        '{1'b1, 8'h20, 32'h5,        4'h0, 8'h20, 32'h5, 1'b0, 4'd7 },  // R7 sw set
        '{1'b1, 8'h28, 32'h4,        4'h0, 8'h24, 32'h4, 1'b1, 4'd8 },  // R8 enabled pending
        '{1'b1, 8'h2C, 32'h4,        4'h0, 8'h2C, 32'h2, 1'b0, 4'd5 },  // R5 disable
        '{1'b1, 8'h50, 32'hF,        4'h0, 8'h20, 32'h5, 1'b0, 4'd10},  // R10 unmapped write
        '{1'b0, 8'h00, 32'h0,        4'h0, 8'h50, 32'h0, 1'b0, 4'd10},  // R10 unmapped read
        '{1'b1, 8'h20, 32'hFFFFFFF0, 4'h0, 8'h20, 32'h5, 1'b0, 4'd10},  // R10 high bits
        '{1'b1, 8'h24, 32'hF,        4'h2, 8'h20, 32'h2, 1'b1, 4'd9 },  // R9 set wins
        '{1'b1, 8'h2C, 32'h2,        4'h0, 8'h24, 32'h0, 1'b0, 4'd5 },  // R5 masked drops
        '{1'b0, 8'h00, 32'h0,        4'h0, 8'h20, 32'h2, 1'b0, 4'd5 }   // R5 raw kept
    };

    task automatic check(input string what, input int req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic peek(input logic [7:0] a, input int req, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check($sformatf("read %h", a), req, reg_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 state after reset
        peek(8'h20, 1, 32'h0);
        peek(8'h24, 1, 32'h0);
        peek(8'h28, 1, 32'h0);
        check("irq after reset", 1, 32'(irq), 32'h0);

        foreach (STEPS[k]) begin
            @(negedge clk);
            reg_wr    = STEPS[k].wr;
            reg_addr  = STEPS[k].waddr;
            reg_wdata = STEPS[k].wdata;
            evt_pulse = STEPS[k].evt;
            @(negedge clk);
            reg_wr = 1'b0; reg_wdata = '0; evt_pulse = '0;
            peek(STEPS[k].raddr, int'(STEPS[k].req), STEPS[k].exp_rd);
            check($sformatf("irq step %0d", k), int'(STEPS[k].req),
                  32'(irq), 32'(STEPS[k].exp_irq));
        end

        // R8 level held across idle cycles, dropped by clear
        write_reg(8'h28, 32'h8);
        write_reg(8'h20, 32'h8);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            #1 check("irq held", 8, 32'(irq), 32'h1);
        end
        write_reg(8'h24, 32'h8);
        #1 check("irq after clear", 8, 32'(irq), 32'h0);
        peek(8'h20, 6, 32'h2);

        // R1 mid-run reset with interrupt active
        write_reg(8'h28, 32'h2);
        #1 check("irq before reset", 8, 32'(irq), 32'h1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1 check("irq after mid reset", 1, 32'(irq), 32'h0);
        peek(8'h20, 1, 32'h0);
        peek(8'h2C, 1, 32'h0);

        // R2 pulse on a disabled bit gives no irq
        @(negedge clk); evt_pulse = 4'h1;
        @(negedge clk); evt_pulse = '0;
        peek(8'h20, 2, 32'h1);
        check("irq disabled pulse", 2, 32'(irq), 32'h0);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule